// File: doc/BRIEF.md
# Unaligned Store Splitter

This block takes one 32-bit store at any byte address and turns it into the beats a strobed data bus needs. The bus is either 4 or 8 bytes wide, chosen by a parameter. Every beat carries three things: an address with the low in-word bits cleared, the store bytes moved onto their byte lanes, and a strobe per lane. A store that sits inside one bus word goes out as a single beat. A store that runs over a bus-word boundary goes out as two beats, and the lower word always goes first.

Both sides use a valid/ready handshake. The output beat is registered. A new store is taken in only when no beat is pending, or in the same cycle that the final beat of the current store is handed off. This lets stores stream back to back with no idle cycle when the downstream side is always ready.

Top module: `store_beat_splitter`

## Requirements
- R1: Every beat address has its low log2(BUS_BYTES) bits equal to zero, and all its other bits are taken from the store address.
- R2: A store at in-word offset `off` with `off + 4 <= BUS_BYTES` produces exactly one beat. That beat's address is the store address with the in-word bits cleared, and strobes `off` to `off+3` are set. For example, a store to 0x1001 on an 8-byte bus gives strobe 0x1E.
- R3: A store with `off + 4 > BUS_BYTES` produces exactly two beats. The first beat has the lower address and strobes `off` to `BUS_BYTES-1`. The second beat has address first + BUS_BYTES, wrapping at the top of the address space, and strobes `0` to `off+3-BUS_BYTES`. For example, offset 2 on a 4-byte bus gives 0xC then 0x3, and 0x48E on an 8-byte bus gives 0xC0 then 0x03.
- R4: Store byte k (`req_data_i[8k+7:8k]`) appears on lane (off+k) mod BUS_BYTES (`beat_data_o[8i+7:8i]`, strobe bit i) of the beat that carries it. Rebuilding the bytes from the strobed lanes in beat order gives back the store data.
- R5: Every byte lane whose strobe is clear carries zero.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, the beat's address, data and strobe stay unchanged and valid stays high in the next cycle.
- R7: `req_ready_o` is high only when no beat is pending, or when the final beat of the current store is accepted in the same cycle. The first beat of an accepted store is valid in the cycle after acceptance. With the downstream side always ready, a store acceptance and a final-beat handoff fall in the same cycle.
- R8: During and right after reset, `beat_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request valid |
| req_ready_o | output | 1 | Store request accepted when high together with valid |
| req_addr_i | input | ADDR_W | Byte address of the store |
| req_data_i | input | 32 | Store data, byte k in bits 8k+7:8k |
| beat_valid_o | output | 1 | Output beat valid |
| beat_ready_i | input | 1 | Downstream accepts the beat |
| beat_addr_o | output | ADDR_W | Bus-word-aligned beat address |
| beat_data_o | output | BUS_BYTES*8 | Lane-shifted data, zero on disabled lanes |
| beat_strb_o | output | BUS_BYTES | Per-lane byte enables |

## Verification
The two events that can share a cycle are the handoff of a store's final beat and the acceptance of the next store. When both happen at once, the same clock edge must retire the old store and load the new one. This is provoked by holding the downstream ready high through long random streams that mix single-beat and crossing stores. The bench counts the cycles in which both handshakes coincide and requires at least one. It checks that every accepted store's first beat is valid in the next cycle. It also rebuilds each store from the logged beats in order, so a store that is dropped, duplicated or mis-ordered at that edge shows up as an address, strobe or data mismatch.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int STORE_BYTES = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LO,
    SEQ_HI
  } seq_state_e;
endpackage

// File: rtl/sbs_lane_map.sv
module sbs_lane_map #(
  parameter  int BUS_BYTES   = 4,
  parameter  int STORE_BYTES = 4,
  localparam int OFF_W       = $clog2(BUS_BYTES),
  localparam int BUS_W       = BUS_BYTES * 8,
  localparam int ST_W        = STORE_BYTES * 8,
  localparam int WIN         = 2 * BUS_BYTES
) (
  input  logic [OFF_W-1:0]     off_i,
  input  logic [ST_W-1:0]      st_data_i,
  output logic [BUS_W-1:0]     lo_data_o,
  output logic [BUS_BYTES-1:0] lo_strb_o,
  output logic [BUS_W-1:0]     hi_data_o,
  output logic [BUS_BYTES-1:0] hi_strb_o,
  output logic                 span_o
);
  // two-word window: lane j of the window gets store byte (j - off)
  logic [WIN*8-1:0] win_data;
  logic [WIN-1:0]   win_strb;

  for (genvar j = 0; j < WIN; j++) begin : g_lane
    logic [7:0] byte_d;
    logic       en_d;
    always_comb begin
      byte_d = '0;
      en_d   = 1'b0;
      for (int k = 0; k < STORE_BYTES; k++) begin
        if (int'(off_i) + k == j) begin
          byte_d = st_data_i[k*8 +: 8];
          en_d   = 1'b1;
        end
      end
    end
    assign win_data[j*8 +: 8] = byte_d;
    assign win_strb[j]        = en_d;
  end

  assign lo_data_o = win_data[BUS_W-1:0];
  assign hi_data_o = win_data[2*BUS_W-1:BUS_W];
  assign lo_strb_o = win_strb[BUS_BYTES-1:0];
  assign hi_strb_o = win_strb[WIN-1:BUS_BYTES];
  assign span_o    = (int'(off_i) + STORE_BYTES) > BUS_BYTES;
endmodule

// File: rtl/sbs_beat_seq.sv
module sbs_beat_seq
  import sbs_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int BUS_BYTES = 4,
  localparam int OFF_W     = $clog2(BUS_BYTES),
  localparam int BUS_W     = BUS_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [BUS_W-1:0]     lo_data_i,
  input  logic [BUS_BYTES-1:0] lo_strb_i,
  input  logic [BUS_W-1:0]     hi_data_i,
  input  logic [BUS_BYTES-1:0] hi_strb_i,
  input  logic                 span_i,
  output logic                 beat_valid_o,
  input  logic                 beat_ready_i,
  output logic [ADDR_W-1:0]    beat_addr_o,
  output logic [BUS_W-1:0]     beat_data_o,
  output logic [BUS_BYTES-1:0] beat_strb_o
);
  seq_state_e           state_q;
  logic [ADDR_W-1:0]    base_q;
  logic [BUS_W-1:0]     lo_data_q, hi_data_q;
  logic [BUS_BYTES-1:0] lo_strb_q, hi_strb_q;
  logic                 span_q;
  logic                 last_beat, fire, accept;

  assign beat_valid_o = (state_q != SEQ_IDLE);
  assign last_beat    = (state_q == SEQ_HI) || (state_q == SEQ_LO && !span_q);
  assign fire         = beat_valid_o && beat_ready_i;
  // take the next store on the edge that retires the final beat
  assign req_ready_o  = !beat_valid_o || (fire && last_beat);
  assign accept       = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      base_q    <= '0;
      lo_data_q <= '0;
      hi_data_q <= '0;
      lo_strb_q <= '0;
      hi_strb_q <= '0;
      span_q    <= 1'b0;
    end else if (accept) begin
      state_q   <= SEQ_LO;
      base_q    <= base_i;
      lo_data_q <= lo_data_i;
      hi_data_q <= hi_data_i;
      lo_strb_q <= lo_strb_i;
      hi_strb_q <= hi_strb_i;
      span_q    <= span_i;
    end else if (fire) begin
      state_q <= (state_q == SEQ_LO && span_q) ? SEQ_HI : SEQ_IDLE;
    end
  end

  always_comb begin
    if (state_q == SEQ_HI) begin
      beat_addr_o = base_q + ADDR_W'(BUS_BYTES);
      beat_data_o = hi_data_q;
      beat_strb_o = hi_strb_q;
    end else begin
      beat_addr_o = base_q;
      beat_data_o = lo_data_q;
      beat_strb_o = lo_strb_q;
    end
  end

  logic [BUS_W-1:0] strb_bits;
  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_bits
    assign strb_bits[i*8 +: 8] = {8{beat_strb_o[i]}};
  end

  p_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_addr_o[OFF_W-1:0] == '0));

  p_zero_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> ((beat_data_o & ~strb_bits) == '0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
      && $stable(beat_data_o) && $stable(beat_strb_o));

  p_hi_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !last_beat |=> beat_valid_o
      && (beat_addr_o == $past(beat_addr_o) + ADDR_W'(BUS_BYTES)));

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && beat_valid_o |-> beat_ready_i && last_beat);

  p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> beat_valid_o && (beat_addr_o == $past(base_i)));
endmodule

// File: rtl/store_beat_splitter.sv
module store_beat_splitter
  import sbs_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int BUS_BYTES = 4,
  localparam int OFF_W     = $clog2(BUS_BYTES),
  localparam int BUS_W     = BUS_BYTES * 8,
  localparam int ST_W      = STORE_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [ST_W-1:0]      req_data_i,
  output logic                 beat_valid_o,
  input  logic                 beat_ready_i,
  output logic [ADDR_W-1:0]    beat_addr_o,
  output logic [BUS_W-1:0]     beat_data_o,
  output logic [BUS_BYTES-1:0] beat_strb_o
);
  logic [OFF_W-1:0]     off;
  logic [ADDR_W-1:0]    base;
  logic [BUS_W-1:0]     lo_data, hi_data;
  logic [BUS_BYTES-1:0] lo_strb, hi_strb;
  logic                 span;

  assign off  = req_addr_i[OFF_W-1:0];
  assign base = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  sbs_lane_map #(
    .BUS_BYTES  (BUS_BYTES),
    .STORE_BYTES(STORE_BYTES)
  ) u_lane_map (
    .off_i    (off),
    .st_data_i(req_data_i),
    .lo_data_o(lo_data),
    .lo_strb_o(lo_strb),
    .hi_data_o(hi_data),
    .hi_strb_o(hi_strb),
    .span_o   (span)
  );

  sbs_beat_seq #(
    .ADDR_W   (ADDR_W),
    .BUS_BYTES(BUS_BYTES)
  ) u_beat_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .base_i      (base),
    .lo_data_i   (lo_data),
    .lo_strb_i   (lo_strb),
    .hi_data_i   (hi_data),
    .hi_strb_i   (hi_strb),
    .span_i      (span),
    .beat_valid_o(beat_valid_o),
    .beat_ready_i(beat_ready_i),
    .beat_addr_o (beat_addr_o),
    .beat_data_o (beat_data_o),
    .beat_strb_o (beat_strb_o)
  );

  p_strb_total_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ($countones(lo_strb) + $countones(hi_strb) == STORE_BYTES));

  p_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && span |-> (hi_strb != '0) && lo_strb[BUS_BYTES-1]);
endmodule

// File: tb/store_beat_splitter_test.sv
module store_beat_splitter_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        sel8;
  logic        req_valid;
  logic [31:0] req_addr, req_data;
  logic        beat_ready;

  logic        r4, b4_valid;
  logic [31:0] b4_addr, b4_data;
  logic [3:0]  b4_strb;
  logic        r8, b8_valid;
  logic [31:0] b8_addr;
  logic [63:0] b8_data;
  logic [7:0]  b8_strb;
  logic        v4, v8;

  assign v4 = req_valid && !sel8;
  assign v8 = req_valid && sel8;

  store_beat_splitter #(.ADDR_W(32), .BUS_BYTES(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v4), .req_ready_o(r4),
    .req_addr_i(req_addr), .req_data_i(req_data), .beat_valid_o(b4_valid),
    .beat_ready_i(beat_ready), .beat_addr_o(b4_addr), .beat_data_o(b4_data),
    .beat_strb_o(b4_strb));

  store_beat_splitter #(.ADDR_W(32), .BUS_BYTES(8)) uut_wide (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v8), .req_ready_o(r8),
    .req_addr_i(req_addr), .req_data_i(req_data), .beat_valid_o(b8_valid),
    .beat_ready_i(beat_ready), .beat_addr_o(b8_addr), .beat_data_o(b8_data),
    .beat_strb_o(b8_strb));

  logic        m_rdy, m_valid;
  logic [31:0] m_addr;
  logic [63:0] m_data;
  logic [7:0]  m_strb;
  assign m_rdy   = sel8 ? r8 : r4;
  assign m_valid = sel8 ? b8_valid : b4_valid;
  assign m_addr  = sel8 ? b8_addr : b4_addr;
  assign m_data  = sel8 ? b8_data : {32'h0, b4_data};
  assign m_strb  = sel8 ? b8_strb : {4'h0, b4_strb};

  int checks = 0, errors = 0, overlap = 0;
  logic [31:0] st_addr [64];
  logic [31:0] st_data [64];
  int          n_st;
  logic [31:0] lg_addr [128];
  logic [63:0] lg_data [128];
  logic [7:0]  lg_strb [128];
  int          n_lg;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_stream(input bit wide, input bit always_rdy);
    int idx = 0;
    bit acc_prev = 0, stall_prev = 0, done = 0;
    logic [31:0] p_addr = '0;
    logic [63:0] p_data = '0;
    logic [7:0]  p_strb = '0;
    @(negedge clk);
    req_valid = 1'b0;
    sel8 = wide;
    n_lg = 0;
    while (!done) begin
      @(negedge clk);
      if (acc_prev) chk(m_valid, "R7", "first beat valid after accept", 64'(m_valid), 64'd1);
      if (stall_prev)
        chk(m_valid && m_addr == p_addr && m_data == p_data && m_strb == p_strb,
            "R6", "beat held under stall", m_data, p_data);
      if (idx == n_st && !m_valid) begin
        done = 1;
        req_valid = 1'b0;
      end else begin
        beat_ready = always_rdy ? 1'b1 : ($urandom % 4 != 0);
        req_valid  = (idx < n_st);
        req_addr   = (idx < n_st) ? st_addr[idx] : '0;
        req_data   = (idx < n_st) ? st_data[idx] : '0;
        #1;
        if (m_valid && m_rdy)
          chk(beat_ready == 1'b1, "R7", "ready while beat pending", 64'(beat_ready), 64'd1);
        if (req_valid && m_rdy && m_valid && beat_ready) overlap++;
        if (m_valid && beat_ready && n_lg < 128) begin
          lg_addr[n_lg] = m_addr;
          lg_data[n_lg] = m_data;
          lg_strb[n_lg] = m_strb;
          n_lg++;
        end
        stall_prev = m_valid && !beat_ready;
        p_addr = m_addr; p_data = m_data; p_strb = m_strb;
        acc_prev = req_valid && m_rdy;
        if (acc_prev) idx++;
      end
    end
  endtask

  task automatic verify(input bit wide);
    int w = wide ? 8 : 4;
    int li = 0;
    for (int s = 0; s < n_st; s++) begin
      int off = int'(st_addr[s] % 32'(w));
      bit two = (off + 4) > w;
      int nb = two ? 2 : 1;
      logic [31:0] base = st_addr[s] & ~(32'(w) - 32'd1);
      logic [15:0] ws = 16'h000F << off;
      logic [7:0]  es [2];
      logic [31:0] rb = '0;
      bit bad = 0, zero_ok = 1;
      es[0] = wide ? ws[7:0]  : {4'h0, ws[3:0]};
      es[1] = wide ? ws[15:8] : {4'h0, ws[7:4]};
      if (li + nb > n_lg) begin
        chk(0, two ? "R3" : "R2", "missing beats", 64'(n_lg), 64'(li + nb));
        break;
      end
      for (int b = 0; b < nb; b++) begin
        logic [31:0] a = lg_addr[li+b];
        chk(a % 32'(w) == 0, "R1", "beat address aligned", 64'(a), 64'(base));
        chk(a == base + 32'(b * w), two ? "R3" : "R2", "beat address", 64'(a),
            64'(base + 32'(b * w)));
        chk(lg_strb[li+b] == es[b], two ? "R3" : "R2", "beat strobe",
            64'(lg_strb[li+b]), 64'(es[b]));
        for (int ln = 0; ln < w; ln++) begin
          logic [7:0] bv = lg_data[li+b][ln*8 +: 8];
          if (lg_strb[li+b][ln]) begin
            int pos = b * w + ln - off;
            if (pos >= 0 && pos < 4) rb[pos*8 +: 8] = bv;
            else bad = 1;
          end else if (bv != 8'h00) zero_ok = 0;
        end
      end
      chk(zero_ok, "R5", "disabled lanes zero", lg_data[li], 64'h0);
      chk(!bad && rb == st_data[s], "R4", "rebuilt store bytes", 64'(rb), 64'(st_data[s]));
      li += nb;
    end
    chk(li == n_lg, "R3", "beat count per stream", 64'(n_lg), 64'(li));
  endtask

  task automatic one_store(input bit wide, input logic [31:0] a, input logic [31:0] d);
    n_st = 1; st_addr[0] = a; st_data[0] = d;
    run_stream(wide, 1'b0);
    verify(wide);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; sel8 = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!b4_valid && !b8_valid && r4 && r8, "R8", "in reset", {b4_valid, b8_valid, r4, r8}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!b4_valid && !b8_valid && r4 && r8, "R8", "after reset", {b4_valid, b8_valid, r4, r8}, 4'b0011);

    // directed corners
    one_store(1'b0, 32'h0000_0002, 32'hA1B2_C3D4);
    chk(n_lg == 2 && lg_strb[0] == 8'h0C && lg_strb[1] == 8'h03, "R3", "4B off2 strobes",
        {lg_strb[0], lg_strb[1]}, 16'h0C03);
    one_store(1'b1, 32'h0000_1001, 32'h1122_3344);
    chk(n_lg == 1 && lg_strb[0] == 8'h1E && lg_addr[0] == 32'h1000, "R2", "8B 0x1001 single beat",
        {lg_addr[0], lg_strb[0]}, {32'h1000, 8'h1E});
    one_store(1'b1, 32'h0000_048E, 32'hCAFE_F00D);
    chk(n_lg == 2 && lg_strb[0] == 8'hC0 && lg_strb[1] == 8'h03 && lg_addr[0] == 32'h488
        && lg_addr[1] == 32'h490, "R3", "8B 0x48E two beats",
        {lg_addr[1], lg_strb[0], lg_strb[1]}, {32'h490, 16'hC003});
    one_store(1'b0, 32'hFFFF_FFFD, 32'h5566_7788);
    chk(n_lg == 2 && lg_addr[1] == 32'h0, "R3", "4B second beat wraps", 64'(lg_addr[1]), 64'h0);
    one_store(1'b1, 32'hFFFF_FFFE, 32'h99AA_BBCC);
    chk(n_lg == 2 && lg_addr[1] == 32'h0, "R3", "8B second beat wraps", 64'(lg_addr[1]), 64'h0);

    // every offset, both widths, random ready
    for (int wd = 0; wd < 2; wd++) begin
      int w = wd ? 8 : 4;
      n_st = 2 * w;
      for (int o = 0; o < 2 * w; o++) begin
        st_addr[o] = ($urandom & 32'hFFFF_FFF0) | 32'(o);
        st_data[o] = $urandom;
      end
      run_stream(wd[0], 1'b0);
      verify(wd[0]);
    end

    // back-to-back with downstream always ready
    for (int wd = 0; wd < 2; wd++) begin
      overlap = 0;
      n_st = 32;
      for (int s = 0; s < 32; s++) begin st_addr[s] = $urandom; st_data[s] = $urandom; end
      run_stream(wd[0], 1'b1);
      verify(wd[0]);
      chk(overlap > 0, "R7", "accept with final-beat handoff same cycle", 64'(overlap), 64'd1);
    end

    // random streams with random stalls
    for (int r = 0; r < 4; r++) begin
      n_st = 40;
      for (int s = 0; s < 40; s++) begin st_addr[s] = $urandom; st_data[s] = $urandom; end
      run_stream(r[0], 1'b0);
      verify(r[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule